// File: doc/BRIEF.md
# Dual-Port RAM With Byte Lanes

This block is a true dual-port synchronous RAM. Its two ports, A and B, are fully independent. Each port has its own clock and reset, its own burst address counter, its own pair of chip enables, and its own write/read select. Each port also has an output enable, two byte-lane selects and a latency mode select. Either port can read or write any word at any time, and both ports may access the same word at once. The data word is split into a low lane and a high lane of equal width. A write touches only the selected lanes. A read drives only the lanes that are both selected and enabled for output.

Each port takes its address from a counter register. The counter can be loaded from the address input, cleared to zero, stepped by one, or held, and the access in that cycle uses the resulting value. That makes burst transfers possible without presenting a new address every clock. No tri-state driver is used. A lane that is not driven reads as zero, and a per-lane valid flag reports which lanes carry data. Read latency is chosen per port: one clock in flow-through mode or two clocks in pipelined mode.

Top module: `dpr_top`

## Requirements
- R1: A port is selected only while its first chip enable (`x_en0_n`) is 0 and its second chip enable (`x_en1`) is 1 in the same cycle. An unselected port writes nothing and produces no valid read data.
- R2: On a selected port, `x_wr_n` = 0 performs a write at the rising clock edge and `x_wr_n` = 1 performs a read.
- R3: A write updates the low lane (bits LANE_W-1..0, with LANE_W = DATA_W/2) only when `x_lo_n` = 0. It updates the high lane (bits DATA_W-1..LANE_W) only when `x_hi_n` = 0. A lane that is not selected keeps its stored value.
- R4: `x_rvalid[0]` refers to the low lane and `x_rvalid[1]` to the high lane. A lane's valid bit is 1 only for read data of a selected read whose lane select was 0, and only while `x_oe_n` is 0. The output enable acts without a clock. A lane whose valid bit is 0 reads as all zeros on `x_rdata`.
- R5: With `x_pipe` = 0 (flow-through), read data appears one clock edge after the edge that captures the read. With `x_pipe` = 1 (pipelined), it appears two edges after. Each port's mode is independent of the other port's mode.
- R6: Every cycle the address counter takes a new value, with this priority. If `x_clear_n` = 0 it becomes 0. Otherwise, if `x_load_n` = 0 it becomes `x_addr`. Otherwise, if `x_step_n` = 0 it becomes the old value plus one, wrapping from the last word to 0. Otherwise it holds. The access in that cycle uses this new value.
- R7: Both ports may read the same word in the same cycle. A word that one port writes can be read by the other port in the same cycle. That read returns the value from before the write, and a read in the next cycle returns the new value.
- R8: During reset, and after it until a read completes, a port's outputs are zero with all valid bits 0. Reset sets the address counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A reset, active low |
| a_addr | input | ADDR_W | Port A address for counter load |
| a_load_n | input | 1 | Port A counter load, active low |
| a_step_n | input | 1 | Port A counter step, active low |
| a_clear_n | input | 1 | Port A counter clear, active low, highest priority |
| a_en0_n | input | 1 | Port A chip enable, active low |
| a_en1 | input | 1 | Port A chip enable, active high |
| a_wr_n | input | 1 | Port A write (0) or read (1) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_lo_n | input | 1 | Port A low lane select, active low |
| a_hi_n | input | 1 | Port A high lane select, active low |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero on undriven lanes |
| a_rvalid | output | 2 | Port A per-lane valid (bit 0 low lane) |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B reset, active low |
| b_addr | input | ADDR_W | Port B address for counter load |
| b_load_n | input | 1 | Port B counter load, active low |
| b_step_n | input | 1 | Port B counter step, active low |
| b_clear_n | input | 1 | Port B counter clear, active low, highest priority |
| b_en0_n | input | 1 | Port B chip enable, active low |
| b_en1 | input | 1 | Port B chip enable, active high |
| b_wr_n | input | 1 | Port B write (0) or read (1) |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_lo_n | input | 1 | Port B low lane select, active low |
| b_hi_n | input | 1 | Port B high lane select, active low |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero on undriven lanes |
| b_rvalid | output | 2 | Port B per-lane valid (bit 0 low lane) |

## Verification
On every cycle the assertions check four things. They check the counter priority and wrap, and that no lane is valid while the output enable is high or after the port has been unselected for two cycles. They check that an undriven lane is all zeros. They check that each read's lane flags arrive after one or two edges, according to the mode. Stored contents can only be shown by the bench's scenarios, which write and read back through the ports. These scenarios cover partial-lane writes that preserve the other lane, writes ignored by an unselected port, and bursts that wrap around the top address. They also cover same-cycle reads of one word from both ports, and the old-value result when one port reads a word that the other port is writing.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } dpr_mode_e;

  // active-low lane selects to active-high lane enables, bit 0 = low lane
  function automatic logic [1:0] lane_pick(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

  function automatic logic port_chosen(input logic en0_n, input logic en1);
    return ~en0_n & en1;
  endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
`timescale 1ns/1ps
module dpr_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0] cnt_q;

  function automatic logic [ADDR_W-1:0] pick_addr(
    input logic [ADDR_W-1:0] held,
    input logic [ADDR_W-1:0] ext,
    input logic              cl_n,
    input logic              ld_n,
    input logic              st_n
  );
    if (!cl_n)      return '0;
    else if (!ld_n) return ext;
    else if (!st_n) return held + 1'b1;
    else            return held;
  endfunction

  assign cur_addr = pick_addr(cnt_q, ext_addr, clear_n, load_n, step_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cur_addr;
  end

  // R6
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> cnt_q == '0);
  // R6
  load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && !load_n |=> cnt_q == $past(ext_addr));
  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && load_n && !step_n |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && load_n && step_n |=> $stable(cnt_q));

endmodule

// File: rtl/dpr_read_pipe.sv
`timescale 1ns/1ps
module dpr_read_pipe
  import dpr_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [1:0]        lane_en,
  input  logic              pipe,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rvalid
);

  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] s1_d, s2_d, pick_d;
  logic [1:0]        s1_en, s2_en, pick_en;
  dpr_mode_e         mode;

  assign mode = dpr_mode_e'(pipe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_en <= '0;
      s2_en <= '0;
      s1_d  <= '0;
      s2_d  <= '0;
    end else begin
      s1_en <= rd_fire ? lane_en : 2'b00;
      if (rd_fire) s1_d <= word_in;
      s2_en <= s1_en;
      s2_d  <= s1_d;
    end
  end

  assign pick_en = (mode == MODE_PIPE) ? s2_en : s1_en;
  assign pick_d  = (mode == MODE_PIPE) ? s2_d  : s1_d;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign rvalid[l] = pick_en[l] & ~oe_n;
    assign rdata[l*LANE_W +: LANE_W] = rvalid[l] ? pick_d[l*LANE_W +: LANE_W] : '0;
  end

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid != 2'b00 |-> !oe_n);
  // R4
  lo_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid[0] |-> rdata[LANE_W-1:0] == '0);
  // R4
  hi_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid[1] |-> rdata[DATA_W-1:LANE_W] == '0);
  // R5
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (mode != MODE_FLOW) || oe_n || (rvalid == $past(lane_en)));
  // R5
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ##1 ((mode != MODE_PIPE) || oe_n || (rvalid == $past(lane_en, 2))));

endmodule

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
module dpr_bank #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              clk_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [1:0]        wmask_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rword_a,
  input  logic              clk_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [1:0]        wmask_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rword_b
);

  localparam int LANE_W = DATA_W / 2;
  localparam int DEPTH  = 1 << ADDR_W;

  // Each port owns one copy; the stored word is the XOR of both copies.
  logic [DATA_W-1:0] copy_a [DEPTH];
  logic [DATA_W-1:0] copy_b [DEPTH];

  always_ff @(posedge clk_a) begin
    for (int l = 0; l < 2; l++) begin
      if (wmask_a[l])
        copy_a[addr_a][l*LANE_W +: LANE_W] <=
          wdata_a[l*LANE_W +: LANE_W] ^ copy_b[addr_a][l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_b) begin
    for (int l = 0; l < 2; l++) begin
      if (wmask_b[l])
        copy_b[addr_b][l*LANE_W +: LANE_W] <=
          wdata_b[l*LANE_W +: LANE_W] ^ copy_a[addr_b][l*LANE_W +: LANE_W];
    end
  end

  assign rword_a = copy_a[addr_a] ^ copy_b[addr_a];
  assign rword_b = copy_a[addr_b] ^ copy_b[addr_b];

endmodule

// File: rtl/dpr_top.sv
`timescale 1ns/1ps
module dpr_top
  import dpr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_load_n,
  input  logic              a_step_n,
  input  logic              a_clear_n,
  input  logic              a_en0_n,
  input  logic              a_en1,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic              a_lo_n,
  input  logic              a_hi_n,
  input  logic              a_pipe,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [1:0]        a_rvalid,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_load_n,
  input  logic              b_step_n,
  input  logic              b_clear_n,
  input  logic              b_en0_n,
  input  logic              b_en1,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic              b_lo_n,
  input  logic              b_hi_n,
  input  logic              b_pipe,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [1:0]        b_rvalid
);

  localparam int NPORT = 2;

  logic [NPORT-1:0] p_clk, p_rst_n, p_load_n, p_step_n, p_clear_n;
  logic [NPORT-1:0] p_en0_n, p_en1, p_wr_n, p_oe_n, p_lo_n, p_hi_n, p_pipe;
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [ADDR_W-1:0] p_cur   [NPORT];
  logic [DATA_W-1:0] p_wdata [NPORT];
  logic [DATA_W-1:0] p_rword [NPORT];
  logic [DATA_W-1:0] p_rdata [NPORT];
  logic [1:0]        p_rvalid[NPORT];
  logic [1:0]        p_wmask [NPORT];

  // named internal events per port
  logic [NPORT-1:0] p_sel, p_wr_fire, p_rd_fire;

  assign p_clk     = {b_clk,     a_clk};
  assign p_rst_n   = {b_rst_n,   a_rst_n};
  assign p_load_n  = {b_load_n,  a_load_n};
  assign p_step_n  = {b_step_n,  a_step_n};
  assign p_clear_n = {b_clear_n, a_clear_n};
  assign p_en0_n   = {b_en0_n,   a_en0_n};
  assign p_en1     = {b_en1,     a_en1};
  assign p_wr_n    = {b_wr_n,    a_wr_n};
  assign p_oe_n    = {b_oe_n,    a_oe_n};
  assign p_lo_n    = {b_lo_n,    a_lo_n};
  assign p_hi_n    = {b_hi_n,    a_hi_n};
  assign p_pipe    = {b_pipe,    a_pipe};
  assign p_addr[0]  = a_addr;
  assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata;
  assign p_wdata[1] = b_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [1:0] lanes;

    assign p_sel[p]     = port_chosen(p_en0_n[p], p_en1[p]);
    assign p_wr_fire[p] = p_sel[p] & ~p_wr_n[p];
    assign p_rd_fire[p] = p_sel[p] &  p_wr_n[p];
    assign lanes        = lane_pick(p_lo_n[p], p_hi_n[p]);
    assign p_wmask[p]   = p_wr_fire[p] ? lanes : 2'b00;

    dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk      (p_clk[p]),
      .rst_n    (p_rst_n[p]),
      .ext_addr (p_addr[p]),
      .load_n   (p_load_n[p]),
      .step_n   (p_step_n[p]),
      .clear_n  (p_clear_n[p]),
      .cur_addr (p_cur[p])
    );

    dpr_read_pipe #(.DATA_W(DATA_W)) u_rd (
      .clk     (p_clk[p]),
      .rst_n   (p_rst_n[p]),
      .rd_fire (p_rd_fire[p]),
      .lane_en (lanes),
      .pipe    (p_pipe[p]),
      .oe_n    (p_oe_n[p]),
      .word_in (p_rword[p]),
      .rdata   (p_rdata[p]),
      .rvalid  (p_rvalid[p])
    );

    // R2
    rw_excl_chk: assert property (@(posedge p_clk[p]) disable iff (!p_rst_n[p])
      !(p_wr_fire[p] && p_rd_fire[p]));
    // R1
    sel_gate_chk: assert property (@(posedge p_clk[p]) disable iff (!p_rst_n[p])
      (!p_sel[p] ##1 !p_sel[p]) |=> p_rvalid[p] == 2'b00);
  end

  dpr_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_a   (p_clk[0]),
    .addr_a  (p_cur[0]),
    .wmask_a (p_wmask[0]),
    .wdata_a (p_wdata[0]),
    .rword_a (p_rword[0]),
    .clk_b   (p_clk[1]),
    .addr_b  (p_cur[1]),
    .wmask_b (p_wmask[1]),
    .wdata_b (p_wdata[1]),
    .rword_b (p_rword[1])
  );

  assign a_rdata  = p_rdata[0];
  assign a_rvalid = p_rvalid[0];
  assign b_rdata  = p_rdata[1];
  assign b_rvalid = p_rvalid[1];

endmodule

// File: tb/tb_dpr_top.sv
`timescale 1ns/1ps
module tb_dpr_top;

  localparam int AW    = 8;
  localparam int DW    = 18;
  localparam int LW    = DW / 2;
  localparam int DEPTH = 1 << AW;

  localparam int OP_HOLD = 0, OP_LOAD = 1, OP_STEP = 2, OP_CLR = 3, OP_CLRLD = 4;

  typedef struct packed {
    logic [31:0]   due;
    logic [1:0]    lanes;
    logic [DW-1:0] data;
    logic [7:0]    req;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] d_addr [2];
  logic [DW-1:0] d_wdata[2];
  logic [1:0] d_load_n, d_step_n, d_clear_n, d_en0_n, d_en1, d_wr_n;
  logic [1:0] d_oe_n, d_lo_n, d_hi_n, d_pipe;
  logic [7:0] d_req[2];
  logic [DW-1:0] a_rdata, b_rdata;
  logic [1:0]    a_rvalid, b_rvalid;

  logic [DW-1:0] mdl [DEPTH];
  logic [AW-1:0] cnt [2];
  item_t qa[$];
  item_t qb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] idle_req = 8'd4;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  dpr_top #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .a_clk(clk), .a_rst_n(rst_n), .a_addr(d_addr[0]), .a_load_n(d_load_n[0]),
    .a_step_n(d_step_n[0]), .a_clear_n(d_clear_n[0]), .a_en0_n(d_en0_n[0]),
    .a_en1(d_en1[0]), .a_wr_n(d_wr_n[0]), .a_oe_n(d_oe_n[0]), .a_lo_n(d_lo_n[0]),
    .a_hi_n(d_hi_n[0]), .a_pipe(d_pipe[0]), .a_wdata(d_wdata[0]),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst_n(rst_n), .b_addr(d_addr[1]), .b_load_n(d_load_n[1]),
    .b_step_n(d_step_n[1]), .b_clear_n(d_clear_n[1]), .b_en0_n(d_en0_n[1]),
    .b_en1(d_en1[1]), .b_wr_n(d_wr_n[1]), .b_oe_n(d_oe_n[1]), .b_lo_n(d_lo_n[1]),
    .b_hi_n(d_hi_n[1]), .b_pipe(d_pipe[1]), .b_wdata(d_wdata[1]),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  function automatic logic [DW-1:0] bits_of(input logic [1:0] lanes);
    return {{LW{lanes[1]}}, {LW{lanes[0]}}};
  endfunction

  task automatic idle_port(input int p);
    d_en0_n[p] = 1'b1; d_en1[p] = 1'b0; d_wr_n[p] = 1'b1;
    d_load_n[p] = 1'b1; d_step_n[p] = 1'b1; d_clear_n[p] = 1'b1;
    d_lo_n[p] = 1'b0; d_hi_n[p] = 1'b0; d_oe_n[p] = 1'b0;
    d_addr[p] = '0; d_wdata[p] = '0; d_req[p] = 8'd0;
  endtask

  task automatic set_port(input int p, input int op, input logic wr,
                          input logic lo_n, input logic hi_n,
                          input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                          input logic [7:0] rq);
    d_en0_n[p] = 1'b0; d_en1[p] = 1'b1; d_wr_n[p] = ~wr;
    d_lo_n[p] = lo_n; d_hi_n[p] = hi_n; d_addr[p] = ad; d_wdata[p] = wd;
    d_clear_n[p] = !(op == OP_CLR || op == OP_CLRLD);
    d_load_n[p]  = !(op == OP_LOAD || op == OP_CLRLD);
    d_step_n[p]  = !(op == OP_STEP || op == OP_CLR);
    d_req[p] = rq;
  endtask

  // One clock: model the cycle, push expected reads, advance, restore idle.
  task automatic tick();
    logic [AW-1:0] eff [2];
    logic [DW-1:0] m [2];
    logic          sel [2];
    item_t it;
    for (int p = 0; p < 2; p++) begin
      if (!rst_n)              eff[p] = '0;
      else if (!d_clear_n[p])  eff[p] = '0;
      else if (!d_load_n[p])   eff[p] = d_addr[p];
      else if (!d_step_n[p])   eff[p] = cnt[p] + 1'b1;
      else                     eff[p] = cnt[p];
      cnt[p] = eff[p];
      sel[p] = rst_n && !d_en0_n[p] && d_en1[p];
      m[p]   = bits_of({!d_hi_n[p], !d_lo_n[p]});
      if (sel[p] && d_wr_n[p] && (m[p] != '0)) begin
        it.due   = cyc + 1 + (d_pipe[p] ? 1 : 0);
        it.lanes = {!d_hi_n[p], !d_lo_n[p]};
        it.data  = mdl[eff[p]] & m[p];
        it.req   = d_req[p];
        if (p == 0) qa.push_back(it); else qb.push_back(it);
      end
    end
    for (int p = 0; p < 2; p++)
      if (sel[p] && !d_wr_n[p])
        mdl[eff[p]] = (mdl[eff[p]] & ~m[p]) | (d_wdata[p] & m[p]);
    @(posedge clk);
    @(negedge clk);
    #1;
    idle_port(0);
    idle_port(1);
  endtask

  task automatic check_port(input int p, input logic has, input item_t it);
    logic [DW-1:0] gd, ed;
    logic [1:0]    gv, ev;
    logic          oe;
    logic [7:0]    rq;
    gd = (p == 0) ? a_rdata  : b_rdata;
    gv = (p == 0) ? a_rvalid : b_rvalid;
    oe = d_oe_n[p];
    if (has) begin
      ev = it.lanes & {2{~oe}};
      ed = it.data & bits_of(ev);
      rq = it.req;
    end else begin
      ev = 2'b00; ed = '0; rq = idle_req;
    end
    n_chk++;
    if (gd !== ed || gv !== ev) begin
      n_fail++;
      $display("FAIL R%0d port %0d cycle %0d: data %h valid %b, expected data %h valid %b",
               rq, p, cyc, gd, gv, ed, ev);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (qa.size() != 0 && qa[0].due == cyc) check_port(0, 1'b1, qa.pop_front());
      else                                    check_port(0, 1'b0, '0);
      if (qb.size() != 0 && qb[0].due == cyc) check_port(1, 1'b1, qb.pop_front());
      else                                    check_port(1, 1'b0, '0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running, expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    cnt[0] = '0; cnt[1] = '0;
    d_pipe = 2'b00;
    idle_port(0); idle_port(1);
    rst_n = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;
    idle_req = 8'd8;                       // R8: outputs quiet in reset
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R8: counter is 0 after reset, hold op writes word 0
    set_port(0, OP_HOLD, 1'b1, 1'b0, 1'b0, 8'd99, 18'h2A5A5, 8'd8);
    tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd8);
    tick();
    idle_req = 8'd4;
    tick();

    // R2 R6: burst write 10..13 on A; R5 pipelined burst read on B
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd10, 18'h11111, 8'd2); tick();
    set_port(0, OP_STEP, 1'b1, 1'b0, 1'b0, 8'd0, 18'h12222, 8'd2); tick();
    set_port(0, OP_STEP, 1'b1, 1'b0, 1'b0, 8'd0, 18'h13333, 8'd2); tick();
    set_port(0, OP_STEP, 1'b1, 1'b0, 1'b0, 8'd0, 18'h14444, 8'd2); tick();
    d_pipe[1] = 1'b1;
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd10, '0, 8'd5); tick();
    set_port(1, OP_STEP, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd6); tick();
    set_port(1, OP_STEP, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd6); tick();
    set_port(1, OP_STEP, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd5); tick();
    set_port(1, OP_HOLD, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd6); tick();
    tick(); tick();

    // R3: lane-masked writes keep the other lane
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b1, 8'd10, 18'h3FFFF, 8'd3); tick();
    set_port(0, OP_LOAD, 1'b1, 1'b1, 1'b0, 8'd11, 18'h00000, 8'd3); tick();
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd10, '0, 8'd3); tick();
    set_port(1, OP_STEP, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd3); tick();
    tick(); tick();

    // R4: lane-gated reads and output enable on flow port A
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b1, 8'd12, '0, 8'd4); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b1, 1'b0, 8'd12, '0, 8'd4); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b1, 1'b1, 8'd12, '0, 8'd4); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd13, '0, 8'd4);
    d_oe_n[0] = 1'b1; tick();
    // R4: output enable high on pipelined port B at the output cycle
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd13, '0, 8'd4); tick();
    d_oe_n[1] = 1'b1; tick();
    tick(); tick();

    // R1: writes with either chip enable inactive are ignored
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd14, 18'h05555, 8'd1); tick();
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd14, 18'h0F0F0, 8'd1);
    d_en0_n[0] = 1'b1; tick();
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd14, 18'h30F0F, 8'd1);
    d_en1[0] = 1'b0; tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd14, '0, 8'd1);
    d_en1[0] = 1'b0; tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd14, '0, 8'd1); tick();
    tick(); tick();

    // R7: both ports read one word, then write on A while B reads it
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd20, 18'h0ABCD, 8'd7); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd20, '0, 8'd7);
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd20, '0, 8'd7); tick();
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd20, 18'h1DEAD, 8'd7);
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd20, '0, 8'd7); tick();
    set_port(1, OP_HOLD, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd7); tick();
    tick(); tick();

    // R6: clear beats load, wrap from top address to 0
    set_port(0, OP_CLRLD, 1'b0, 1'b0, 1'b0, 8'd30, '0, 8'd6); tick();
    set_port(0, OP_LOAD, 1'b1, 1'b0, 1'b0, 8'd255, 18'h00077, 8'd6); tick();
    set_port(0, OP_STEP, 1'b1, 1'b0, 1'b0, 8'd0, 18'h00088, 8'd6); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd255, '0, 8'd6); tick();
    set_port(0, OP_STEP, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd6); tick();
    set_port(0, OP_CLR, 1'b0, 1'b0, 1'b0, 8'd0, '0, 8'd6); tick();
    tick(); tick();

    // R5: port A switched to pipelined, port B switched to flow-through
    d_pipe = 2'b01;
    tick(); tick();
    set_port(0, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd11, '0, 8'd5);
    set_port(1, OP_LOAD, 1'b0, 1'b0, 1'b0, 8'd12, '0, 8'd5); tick();
    tick(); tick(); tick();

    finish_run();
  end

endmodule